// File: doc/BRIEF.md
# BCD Millisecond Stopwatch

This block measures the time between two events as a decimal count of milliseconds. The count is held as three BCD digits, from 000 to 999, and it advances once per 1 kHz enable tick while the block is running. A sticky overflow flag records every wrap from 999 to 000, so software that polls and reads the same value twice can tell whether a full second passed in between. The flag clears when the second control register is read.

Counting is started and stopped in one of two ways. In CPU mode a run-enable bit gates the count directly. In pin mode, an external input is synchronised and debounced against a selectable slow tick, either the 4 kHz fine tick or the 250 Hz coarse tick. Each active edge of the debounced pin then toggles the run state. A separate bit selects whether the falling edge or the rising edge is active. The block also raises a one-cycle interrupt pulse, either every tenth of a second or once per wrap of the full count. The prescaler that makes the ticks lies outside the block.

The run state is a two-state machine: HALT and COUNT. Its transitions are START_CPU (HALT to COUNT when run-enable is set in CPU mode), STOP_CPU (COUNT to HALT when run-enable is clear in CPU mode), PIN_START (HALT to COUNT on a trigger event in pin mode) and PIN_STOP (COUNT to HALT on a trigger event in pin mode). Changing the mode does not change the state by itself.

Top module: `msw_top`

## Requirements
- R1: After reset, all five registers read 0x00 and `irq` is low. Register addresses: 0 is units, 1 is tens, 2 is hundreds (each digit in bits [3:0]), 3 is CTRL_A, 4 is CTRL_B.
- R2: While running, each `tick_1k` advances the count by one in decimal. A digit goes from 9 to 0 and carries into the next digit, and no digit ever holds a value above 9.
- R3: When the count steps from 999 to 000, the overflow flag (CTRL_B bit 3) becomes 1.
- R4: The overflow flag stays set across further counting, and any read of CTRL_B clears it in the cycle after the read.
- R5: Writing 1 to CTRL_A bit 2 clears the count to 000. The same write still sets bits 0 and 1 as written, CTRL_B is unchanged, and bit 2 always reads 0.
- R6: `irq` pulses high for one cycle. With CTRL_B bit 2 = 0 it pulses each time the tens and units digits roll from 99 to 00. With bit 2 = 1 it pulses only on the 999-to-000 wrap.
- R7: In CPU mode (CTRL_A bit 1 = 0), CTRL_A bit 0 gates counting. While the block is stopped, `tick_1k` pulses leave the count unchanged.
- R8: In pin mode (CTRL_A bit 1 = 1), each active edge of the debounced pin toggles the run state. The active edge is falling when CTRL_B bit 0 = 0 (the reset value) and rising when it is 1. The other edge has no effect.
- R9: The debounced pin takes a new level only after the synchronised pin has held that level on two consecutive ticks of the selected debounce tick. CTRL_B bit 1 = 0 selects `tick_fine` and bit 1 = 1 selects `tick_coarse`, and ticks of the unselected source are ignored.
- R10: The trigger is taken from the debounced pin after the edge selection. In pin mode, changing CTRL_B bit 0 so that the selected level goes from inactive to active counts as a trigger event and toggles the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | 1 kHz enable tick that advances the count |
| tick_fine | input | 1 | 4 kHz debounce tick (250 µs) |
| tick_coarse | input | 1 | 250 Hz debounce tick (4 ms) |
| pin_in | input | 1 | Asynchronous external start/stop pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt pulse, one cycle wide |

## Verification
The hardest cases to reach are the pin-mode cases. A trigger event only appears after the pin has passed through the synchroniser and two ticks of the selected debounce source, so the stimulus gives exactly one tick and checks that the block has not started, then gives the second tick. It also pulses the unselected tick source, to show that those ticks are ignored. The event raised by changing the edge bit needs the debounced pin to sit at the level that becomes active, so the bench first leaves the pin low under rising-edge selection and only then switches back to falling-edge selection.

// File: rtl/msw_pkg.sv
package msw_pkg;
    localparam int DIGIT_W  = 4;
    localparam int DIGIT_MAX = 9;

    localparam logic [2:0] ADDR_UNITS    = 3'd0;
    localparam logic [2:0] ADDR_TENS     = 3'd1;
    localparam logic [2:0] ADDR_HUNDREDS = 3'd2;
    localparam logic [2:0] ADDR_CTRL_A   = 3'd3;
    localparam logic [2:0] ADDR_CTRL_B   = 3'd4;

    // CTRL_A bit positions
    localparam int A_RUN_EN   = 0;
    localparam int A_PIN_MODE = 1;
    localparam int A_CLEAR    = 2;
    // CTRL_B bit positions
    localparam int B_EDGE_RISE = 0;
    localparam int B_DEB_SLOW  = 1;
    localparam int B_IRQ_SEC   = 2;
    localparam int B_OVF       = 3;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;
endpackage

// File: rtl/msw_debounce.sv
module msw_debounce #(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic tick_fine,
    input  logic tick_coarse,
    input  logic sel_coarse,
    output logic pin_clean
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   clean_q;
    logic                   sample_tick;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= IDLE_LEVEL;
                else        sync_q <= pin_async;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign sample_tick = sel_coarse ? tick_coarse : tick_fine;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= IDLE_LEVEL;
            clean_q <= IDLE_LEVEL;
        end else if (sample_tick) begin
            prev_q <= sync_q[MSB];
            if (sync_q[MSB] == prev_q) clean_q <= prev_q;
        end
    end

    assign pin_clean = clean_q;
endmodule

// File: rtl/msw_bcd_digit.sv
module msw_bcd_digit
    import msw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               carry_in,
    output logic [DIGIT_W-1:0] digit,
    output logic               carry_out
);
    logic [DIGIT_W-1:0] digit_q;
    logic               at_max;

    assign at_max = (digit_q == DIGIT_W'(DIGIT_MAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        digit_q <= '0;
        else if (clr)      digit_q <= '0;
        else if (carry_in) digit_q <= at_max ? '0 : digit_q + 1'b1;
    end

    assign digit     = digit_q;
    assign carry_out = carry_in & at_max;
endmodule

// File: rtl/msw_run_ctl.sv
module msw_run_ctl
    import msw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_mode,
    input  logic run_en,
    input  logic trig_evt,
    output logic running
);
    run_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (pin_mode) begin
                    if (trig_evt) state_d = ST_COUNT;      // PIN_START
                end else if (run_en) begin
                    state_d = ST_COUNT;                    // START_CPU
                end
            end
            ST_COUNT: begin
                if (pin_mode) begin
                    if (trig_evt) state_d = ST_HALT;       // PIN_STOP
                end else if (!run_en) begin
                    state_d = ST_HALT;                     // STOP_CPU
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_COUNT: running = 1'b1;
            default:  running = 1'b0;
        endcase
    end
endmodule

// File: rtl/msw_top.sv
module msw_top
    import msw_pkg::*;
#(
    parameter int N_DIGITS    = 3,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1k,
    input  logic              tick_fine,
    input  logic              tick_coarse,
    input  logic              pin_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W   = DIGIT_W * N_DIGITS;
    localparam int TENTH_C = 2;   // carry into the hundreds digit

    logic run_en_q, pin_mode_q;
    logic edge_rise_q, deb_slow_q, irq_sec_q, ovf_q, irq_q;
    logic pin_clean, trig_lvl, trig_q, trig_evt, running;
    logic wr_a, wr_b, rd_b, count_clr;
    logic [N_DIGITS:0]  carry;
    logic [CNT_W-1:0]   count;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:3];

    assign wr_a      = bus_wr && (bus_addr == ADDR_CTRL_A);
    assign wr_b      = bus_wr && (bus_addr == ADDR_CTRL_B);
    assign rd_b      = bus_rd && (bus_addr == ADDR_CTRL_B);
    assign count_clr = wr_a && bus_wdata[A_CLEAR];

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en_q    <= 1'b0;
            pin_mode_q  <= 1'b0;
            edge_rise_q <= 1'b0;
            deb_slow_q  <= 1'b0;
            irq_sec_q   <= 1'b0;
        end else begin
            if (wr_a) begin
                run_en_q   <= bus_wdata[A_RUN_EN];
                pin_mode_q <= bus_wdata[A_PIN_MODE];
            end
            if (wr_b) begin
                edge_rise_q <= bus_wdata[B_EDGE_RISE];
                deb_slow_q  <= bus_wdata[B_DEB_SLOW];
                irq_sec_q   <= bus_wdata[B_IRQ_SEC];
            end
        end
    end

    msw_debounce #(
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_LEVEL  (1'b1)
    ) u_deb (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_async   (pin_in),
        .tick_fine   (tick_fine),
        .tick_coarse (tick_coarse),
        .sel_coarse  (deb_slow_q),
        .pin_clean   (pin_clean)
    );

    // edge selection before the edge detector
    assign trig_lvl = pin_clean ^ ~edge_rise_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_lvl;
    end

    assign trig_evt = pin_mode_q & trig_lvl & ~trig_q;

    msw_run_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_mode (pin_mode_q),
        .run_en   (run_en_q),
        .trig_evt (trig_evt),
        .running  (running)
    );

    // digit chain
    assign carry[0] = tick_1k & running;

    generate
        for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
            msw_bcd_digit u_dig (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (count_clr),
                .carry_in  (carry[g]),
                .digit     (count[g*DIGIT_W +: DIGIT_W]),
                .carry_out (carry[g+1])
            );
        end
    endgenerate

    // overflow flag and interrupt pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (carry[N_DIGITS] && !count_clr) ovf_q <= 1'b1;
            else if (rd_b)                     ovf_q <= 1'b0;
            irq_q <= !count_clr && (irq_sec_q ? carry[N_DIGITS] : carry[TENTH_C]);
        end
    end

    assign irq = irq_q;

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_UNITS:    bus_rdata[DIGIT_W-1:0] = count[0 +: DIGIT_W];
            ADDR_TENS:     bus_rdata[DIGIT_W-1:0] = count[DIGIT_W +: DIGIT_W];
            ADDR_HUNDREDS: bus_rdata[DIGIT_W-1:0] = count[2*DIGIT_W +: DIGIT_W];
            ADDR_CTRL_A: begin
                bus_rdata[A_RUN_EN]   = run_en_q;
                bus_rdata[A_PIN_MODE] = pin_mode_q;
            end
            ADDR_CTRL_B: begin
                bus_rdata[B_EDGE_RISE] = edge_rise_q;
                bus_rdata[B_DEB_SLOW]  = deb_slow_q;
                bus_rdata[B_IRQ_SEC]   = irq_sec_q;
                bus_rdata[B_OVF]       = ovf_q;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msw_checker.sv
module msw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_1k,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [11:0] count,
    input logic        running,
    input logic        ovf,
    input logic        irq
);
    logic clr_w, at_top;
    assign clr_w  = bus_wr && (bus_addr == 3'd3) && bus_wdata[2];
    assign at_top = (count == 12'h999);

    p_digits_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count[3:0] <= 4'd9) && (count[7:4] <= 4'd9) && (count[11:8] <= 4'd9));

    p_wrap_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && tick_1k && running && !clr_w) |=> (ovf && count == 12'h000));

    p_ovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd4 && !(at_top && tick_1k && running)) |=> !ovf);

    p_clear_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (count == 12'h000));

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_stopped_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !clr_w) |=> $stable(count));
endmodule

bind msw_top msw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1k   (tick_1k),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count     (count),
    .running   (running),
    .ovf       (ovf_q),
    .irq       (irq)
);

// File: tb/tb_msw_top.sv
module tb_msw_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1k = 1'b0, tick_fine = 1'b0, tick_coarse = 1'b0;
    logic       pin_in = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0, errors = 0, irq_cnt = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    msw_top dut (
        .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .tick_fine(tick_fine),
        .tick_coarse(tick_coarse), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compares reads against the scoreboard and counts irq pulses
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && irq) irq_cnt++;
            if (bus_rd) begin
                item_t it;
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty: actual %02h expected none", bus_rdata);
                end else begin
                    it = sb_q.pop_front();
                    if (bus_rdata !== it.exp) begin
                        errors++;
                        $display("FAIL %s addr %0d: actual %02h expected %02h",
                                 it.tag, it.addr, bus_rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        idle(2);
    endtask

    task automatic rd_exp(logic [2:0] a, logic [7:0] e, string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cnt_exp(int h, int t, int u, string tag);
        rd_exp(3'd2, 8'(h), tag);
        rd_exp(3'd1, 8'(t), tag);
        rd_exp(3'd0, 8'(u), tag);
    endtask

    task automatic ms(int n);
        @(negedge clk);
        repeat (n) begin
            tick_1k = 1'b1;
            @(negedge clk);
        end
        tick_1k = 1'b0;
        idle(2);
    endtask

    task automatic fine(int n);
        repeat (n) begin
            @(negedge clk); tick_fine = 1'b1;
            @(negedge clk); tick_fine = 1'b0;
        end
        idle(4);
    endtask

    task automatic coarse(int n);
        repeat (n) begin
            @(negedge clk); tick_coarse = 1'b1;
            @(negedge clk); tick_coarse = 1'b0;
        end
        idle(4);
    endtask

    task automatic set_pin(logic v);
        @(negedge clk);
        pin_in = v;
        idle(3);
    endtask

    task automatic val_exp(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        for (int a = 0; a < 5; a++) rd_exp(3'(a), 8'h00, "R1 reset");
        val_exp(int'(irq), 0, "R1 irq");

        // R2 counting in CPU mode, tenth-second irq
        wr(3'd3, 8'h01);
        ms(9);
        cnt_exp(0, 0, 9, "R2 units");
        ms(1);
        cnt_exp(0, 1, 0, "R2 carry to tens");
        ms(90);
        cnt_exp(1, 0, 0, "R2 carry to hundreds");
        val_exp(irq_cnt, 1, "R6 tenth irq");

        // R7 stopped count holds
        wr(3'd3, 8'h00);
        ms(50);
        cnt_exp(1, 0, 0, "R7 stopped");

        // R5 clear keeps configuration
        wr(3'd4, 8'h06);
        wr(3'd3, 8'h05);
        cnt_exp(0, 0, 0, "R5 cleared");
        rd_exp(3'd3, 8'h01, "R5 ctrl_a");
        rd_exp(3'd4, 8'h06, "R5 ctrl_b");

        // R3/R4/R6 wrap with one-second irq
        irq_cnt = 0;
        ms(999);
        cnt_exp(9, 9, 9, "R2 top");
        rd_exp(3'd4, 8'h06, "R3 no flag yet");
        ms(1);
        cnt_exp(0, 0, 0, "R3 wrap");
        val_exp(irq_cnt, 1, "R6 second irq");
        ms(5);
        rd_exp(3'd4, 8'h0E, "R4 sticky flag");
        rd_exp(3'd4, 8'h06, "R4 cleared by read");

        // pin mode, falling edge, fine debounce
        wr(3'd3, 8'h04);
        wr(3'd3, 8'h02);
        wr(3'd4, 8'h00);
        set_pin(1'b0);
        coarse(3);
        ms(5);
        cnt_exp(0, 0, 0, "R9 coarse ignored");
        fine(1);
        ms(5);
        cnt_exp(0, 0, 0, "R9 one tick");
        fine(1);
        ms(7);
        cnt_exp(0, 0, 7, "R8 falling start");
        set_pin(1'b1);
        fine(2);
        ms(3);
        cnt_exp(0, 1, 0, "R8 rising ignored");
        set_pin(1'b0);
        fine(2);
        ms(5);
        cnt_exp(0, 1, 0, "R8 falling stop");

        // rising edge selected
        wr(3'd4, 8'h01);
        ms(2);
        cnt_exp(0, 1, 0, "R10 no event");
        set_pin(1'b1);
        fine(2);
        ms(4);
        cnt_exp(0, 1, 4, "R8 rising start");
        set_pin(1'b0);
        fine(2);
        ms(2);
        cnt_exp(0, 1, 6, "R8 falling ignored");
        wr(3'd4, 8'h00);
        ms(3);
        cnt_exp(0, 1, 6, "R10 edge change stops");

        // coarse debounce selected
        wr(3'd4, 8'h02);
        set_pin(1'b1);
        coarse(2);
        set_pin(1'b0);
        fine(3);
        ms(2);
        cnt_exp(0, 1, 6, "R9 fine ignored");
        coarse(2);
        ms(4);
        cnt_exp(0, 2, 0, "R9 coarse start");
        val_exp(irq_cnt, 1, "R6 no extra irq");

        idle(3);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule